// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet receive path and decides, one frame at a time, whether the frame is kept. The decision rests on the frame's 48-bit destination address. When the receive logic has the address, it raises a one-cycle strobe with the address. Two cycles later the filter answers with a one-cycle valid pulse and an accept flag.

Software sets the filter up through a 32-bit write port. That port reaches three kinds of state: a five-bit control register, an enable bitmap with one bit per table entry, and a table of up to 21 station addresses. Each table entry takes two word writes. The accept rule combines two things. The first is a set of class bits, which accept every unicast, every group or every broadcast address. The second is a table comparison, whose sense can be inverted.

The decision engine is a three-state machine:

- `ST_IDLE` waits for a strobe and captures the address.
- `ST_MATCH` compares the captured address against the table and the class bits, and registers the result.
- `ST_REPORT` drives the valid pulse.

The transitions are:

- `ST_IDLE` to `ST_MATCH` when the strobe is seen.
- `ST_MATCH` to `ST_REPORT` always.
- `ST_REPORT` to `ST_IDLE` always.

Top module: `rx_daddr_filter`

## Requirements
- R1: After reset the control register and the enable bitmap are all zero, `decide_valid` is low, and every frame presented is rejected.
- R2: Write address 0 loads the control register from `cfg_wr_data[4:0]`. Write address 1 loads the enable bitmap from `cfg_wr_data[20:0]`. Entry i is loaded in two writes:
  - Address 2+2i takes address bytes 0 to 3, with byte 0 in bits 31:24.
  - Address 3+2i takes bytes 4 and 5 in bits 31:16.
  - On `da_addr`, byte 0 is bits 47:40.
- R3: A table entry takes part in matching only while its enable bit (bit i for entry i) is set.
- R4: Control bit 0 accepts any unicast address, that is, one whose byte 0 has bit 0 clear.
- R5: Control bit 1 accepts any multicast address: byte 0 bit 0 is set and the address is not all ones.
- R6: Control bit 2 accepts the broadcast address, which is all ones. Broadcast does not count as multicast.
- R7: Control bit 3 inverts the table result. With bit 3 set, a hit rejects and a miss accepts.
- R8: Control bit 4 enables table comparison. While bit 4 is clear, the table and the inversion bit have no effect.
- R9: The accept flag is the OR of the enabled class conditions and, when bit 4 is set, the possibly inverted table result.
- R10: Writes to addresses 2+2·21 and above are ignored. They change no entry and no decision.
- R11: A strobe seen in `ST_IDLE` gives exactly one `decide_valid` pulse, two cycles later. A strobe that arrives while a decision is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 6 | Configuration word address |
| cfg_wr_data | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| decide_valid | output | 1 | One-cycle decision pulse |
| decide_accept | output | 1 | Frame accepted, meaningful with decide_valid |

## Verification
The assertions assume two things about the inputs:

- A new address strobe never lands inside the two cycles of a decision already in progress, except where the busy-drop behaviour is itself being tested.
- The control register is stable across the match cycle, so a decision can be related to the control value one cycle earlier.

The stimulus meets both. It writes the configuration only while the engine is idle. It spaces every frame by at least four cycles. It issues back-to-back strobes only in the single directed test for R11.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int MAC_W    = 48;
    localparam int WORD_W   = 32;
    localparam int CTL_W    = 5;

    localparam int CTL_UNI  = 0;
    localparam int CTL_MULT = 1;
    localparam int CTL_BCST = 2;
    localparam int CTL_INV  = 3;
    localparam int CTL_CMP  = 4;

    localparam int GROUP_BIT = MAC_W - 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MATCH  = 2'd1,
        ST_REPORT = 2'd2
    } daf_state_e;

    typedef struct packed {
        logic uni;
        logic multi;
        logic bcast;
    } daf_class_t;
endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 21,
    parameter int CFG_AW      = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CFG_AW-1:0]      wr_addr,
    input  logic [NUM_ENTRIES-1:0] wr_bits,
    output logic [CTL_W-1:0]       ctrl_q,
    output logic [NUM_ENTRIES-1:0] en_q
);
    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(0);
    localparam logic [CFG_AW-1:0] EN_ADDR   = CFG_AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == CTRL_ADDR) begin
            ctrl_q <= wr_bits[CTL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_addr == EN_ADDR) begin
            en_q <= wr_bits;
        end
    end
endmodule

// File: rtl/daf_addr_table.sv
module daf_addr_table
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 21,
    parameter int CFG_AW      = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CFG_AW-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [NUM_ENTRIES-1:0] en,
    input  logic [MAC_W-1:0]       probe,
    output logic                   hit
);
    localparam int HI_W = WORD_W;
    localparam int LO_W = MAC_W - WORD_W;

    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
        localparam logic [CFG_AW-1:0] HI_ADDR = CFG_AW'(2 + 2 * gi);
        localparam logic [CFG_AW-1:0] LO_ADDR = CFG_AW'(3 + 2 * gi);

        logic [HI_W-1:0] hi_q;
        logic [LO_W-1:0] lo_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (wr_en && wr_addr == HI_ADDR) begin
                hi_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
            end else if (wr_en && wr_addr == LO_ADDR) begin
                lo_q <= wr_data[WORD_W-1 -: LO_W];
            end
        end

        assign hit_vec[gi] = en[gi] && ({hi_q, lo_q} == probe);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/daf_classify.sv
module daf_classify
    import daf_pkg::*;
(
    input  logic [MAC_W-1:0] addr,
    output daf_class_t       cls
);
    logic all_ones;
    logic group;

    always_comb begin
        all_ones  = &addr;
        group     = addr[GROUP_BIT];
        cls.bcast = all_ones;
        cls.multi = group && !all_ones;
        cls.uni   = !group;
    end
endmodule

// File: rtl/daf_decide_fsm.sv
module daf_decide_fsm
    import daf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             da_valid,
    input  logic [MAC_W-1:0] da_addr,
    input  logic [CTL_W-1:0] ctrl,
    input  logic             table_hit,
    input  daf_class_t       cls,
    output logic [MAC_W-1:0] addr_q,
    output logic             decide_valid,
    output logic             decide_accept
);
    daf_state_e state_q;
    daf_state_e state_d;
    logic       accept_q;
    logic       accept_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (da_valid) state_d = ST_MATCH;
            ST_MATCH:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (state_q == ST_IDLE && da_valid) begin
            addr_q <= da_addr;
        end
    end

    always_comb begin
        accept_d = (ctrl[CTL_UNI]  && cls.uni)
                || (ctrl[CTL_MULT] && cls.multi)
                || (ctrl[CTL_BCST] && cls.bcast)
                || (ctrl[CTL_CMP]  && (table_hit ^ ctrl[CTL_INV]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
        end else if (state_q == ST_MATCH) begin
            accept_q <= accept_d;
        end
    end

    always_comb begin
        decide_valid  = 1'b0;
        decide_accept = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_MATCH:  ;
            ST_REPORT: begin
                decide_valid  = 1'b1;
                decide_accept = accept_q;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 21,
    parameter int CFG_AW      = $clog2(2 + 2 * NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              decide_valid,
    output logic              decide_accept
);
    logic [CTL_W-1:0]       ctrl_q;
    logic [NUM_ENTRIES-1:0] en_q;
    logic [MAC_W-1:0]       addr_q;
    logic                   table_hit;
    daf_class_t             cls;

    daf_cfg_regs #(.NUM_ENTRIES(NUM_ENTRIES), .CFG_AW(CFG_AW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_bits (cfg_wr_data[NUM_ENTRIES-1:0]),
        .ctrl_q  (ctrl_q),
        .en_q    (en_q)
    );

    daf_addr_table #(.NUM_ENTRIES(NUM_ENTRIES), .CFG_AW(CFG_AW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .en      (en_q),
        .probe   (addr_q),
        .hit     (table_hit)
    );

    daf_classify u_class (
        .addr (addr_q),
        .cls  (cls)
    );

    daf_decide_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .da_valid      (da_valid),
        .da_addr       (da_addr),
        .ctrl          (ctrl_q),
        .table_hit     (table_hit),
        .cls           (cls),
        .addr_q        (addr_q),
        .decide_valid  (decide_valid),
        .decide_accept (decide_accept)
    );
endmodule

// File: rtl/daf_checker.sv
module daf_checker
    import daf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             da_valid,
    input logic             decide_valid,
    input logic             decide_accept,
    input logic [CTL_W-1:0] ctrl_q,
    input daf_class_t       cls
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !decide_valid);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        decide_valid |=> !decide_valid);

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        decide_valid |-> $past(da_valid, 2));

    assert_no_ctrl_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_valid && $past(ctrl_q) == '0) |-> !decide_accept);

    assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({cls.uni, cls.multi, cls.bcast}));
endmodule

bind rx_daddr_filter daf_checker u_daf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .da_valid      (da_valid),
    .decide_valid  (decide_valid),
    .decide_accept (decide_accept),
    .ctrl_q        (ctrl_q),
    .cls           (cls)
);

// File: tb/test_rx_daddr_filter.sv
module test_rx_daddr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        decide_valid;
    logic        decide_accept;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_daddr_filter i_rx_daddr_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_addr   (cfg_wr_addr),
        .cfg_wr_data   (cfg_wr_data),
        .da_valid      (da_valid),
        .da_addr       (da_addr),
        .decide_valid  (decide_valid),
        .decide_accept (decide_accept)
    );

    localparam logic [47:0] E0   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] E5   = 48'h01_00_5E_00_00_07;
    localparam logic [47:0] E20  = 48'hAA_BB_CC_DD_EE_01;
    localparam logic [47:0] UNI  = 48'h02_11_22_33_44_56;
    localparam logic [47:0] MC   = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

    // {ctrl[4:0], enables[20:0], address[47:0], expected}
    // ctrl: bit0 unicast, bit1 multicast, bit2 broadcast, bit3 invert, bit4 compare
    localparam int NV = 16;
    localparam logic [74:0] VEC [NV] = '{
        {5'b10000, 21'h000001, E0,  1'b1},  // R8 table hit
        {5'b10000, 21'h000001, UNI, 1'b0},  // R8 table miss
        {5'b10000, 21'h000000, E0,  1'b0},  // R3 disabled entry
        {5'b10000, 21'h000020, E5,  1'b1},  // R3 entry 5
        {5'b10000, 21'h100000, E20, 1'b1},  // R3 last entry
        {5'b11000, 21'h000001, E0,  1'b0},  // R7 inverted hit
        {5'b11000, 21'h000001, UNI, 1'b1},  // R7 inverted miss
        {5'b00001, 21'h000000, UNI, 1'b1},  // R4 unicast
        {5'b00001, 21'h000000, MC,  1'b0},  // R4 multicast not unicast
        {5'b00010, 21'h000000, MC,  1'b1},  // R5 multicast
        {5'b00010, 21'h000000, BC,  1'b0},  // R6 broadcast not multicast
        {5'b00100, 21'h000000, BC,  1'b1},  // R6 broadcast
        {5'b00100, 21'h000000, UNI, 1'b0},  // R6 unicast not broadcast
        {5'b01000, 21'h000001, UNI, 1'b0},  // R8 invert without compare
        {5'b10010, 21'h000000, MC,  1'b1},  // R9 class OR table
        {5'b00000, 21'h1FFFFF, E0,  1'b0}   // R9 no accept bits
    };

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic load_entry(input int idx, input logic [47:0] mac);
        cfg_write(6'(2 + 2 * idx), mac[47:16]);
        cfg_write(6'(3 + 2 * idx), {mac[15:0], 16'h0});
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Returns at the negedge where the decision should be visible.
    task automatic send_frame(input logic [47:0] mac);
        @(negedge clk);
        da_valid = 1'b1;
        da_addr  = mac;
        @(negedge clk);
        da_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic decide(input string req, input logic [47:0] mac, input logic exp);
        send_frame(mac);
        check(req, decide_valid, 1'b1);
        check(req, decide_accept, exp);
        @(negedge clk);
        check("R11 pulse width", decide_valid, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 valid low in reset", decide_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", decide_valid, 1'b0);
        decide("R1 broadcast rejected after reset", BC, 1'b0);
        decide("R1 unicast rejected after reset", UNI, 1'b0);

        load_entry(0, E0);
        load_entry(5, E5);
        load_entry(20, E20);

        for (int v = 0; v < NV; v++) begin
            cfg_write(6'd0, {27'h0, VEC[v][74:70]});
            cfg_write(6'd1, {11'h0, VEC[v][69:49]});
            decide($sformatf("vector %0d", v), VEC[v][48:1], VEC[v][0]);
        end

        // R2: byte order, a byte-swapped image of entry 0 must miss
        cfg_write(6'd0, 32'h10);
        cfg_write(6'd1, 32'h1);
        decide("R2 swapped bytes miss", 48'h55_44_33_22_11_02, 1'b0);
        load_entry(3, 48'h06_07_08_09_0A_0B);
        cfg_write(6'd1, 32'h8);
        decide("R2 entry 3 words", 48'h06_07_08_09_0A_0B, 1'b1);
        decide("R2 entry 3 low half differs", 48'h06_07_08_09_0A_0C, 1'b0);

        // R10: writes past the table are ignored
        cfg_write(6'd44, 32'hDE_AD_BE_EF);
        cfg_write(6'd45, 32'h12_34_0000);
        cfg_write(6'd63, 32'hFFFF_FFFF);
        cfg_write(6'd1, 32'hFFFF_FFFF);
        decide("R10 out-of-range entry not matched", 48'hDE_AD_BE_EF_12_34, 1'b0);
        decide("R10 entry 0 intact", E0, 1'b1);
        decide("R10 entry 20 intact", E20, 1'b1);

        // R11: strobe during a decision is dropped
        begin
            int pulses = 0;
            @(negedge clk);
            da_valid = 1'b1;
            da_addr  = E0;
            @(negedge clk);
            da_addr  = UNI;
            @(negedge clk);
            da_valid = 1'b0;
            if (decide_valid) pulses++;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (decide_valid) pulses++;
            end
            check("R11 one pulse for back-to-back strobes", pulses == 1, 1'b1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule